// File: doc/BRIEF.md
# Console Memory and Port Decoder

This block sits between an 8-bit processor bus and the memories and peripherals of a small home console. On every bus cycle it looks at the address, the cycle type and a flag that marks the final sub-cycle. It picks exactly one memory region: the boot ROM, 1 KB of work RAM, a RAM overlay from an expansion module, or a banked cartridge. Port cycles are turned into selects for the video chip, the controllers, a tone sound generator and a register-based sound chip that takes three strobe lines. The block also returns the read data for the processor.

The block holds four pieces of state. Two overlay flags let the expansion module hide the boot ROM or the low RAM area behind its own RAM. A controller-mode flag makes a controller read return either keypad bits or direction bits. A cartridge bank register selects the bank shown in the upper cartridge window. All selects and strobes are combinational and valid only while the final sub-cycle is shown. State changes take effect on the clock edge that closes that sub-cycle.

Top module: `console_bus_decoder`

## Requirements
- R1: While `cycEnd` is 0, every select, write enable and sound-chip strobe is 0, `rdData` is 0xFF, and no flag or bank register changes.
- R2: The cycle-type encoding is 1 opcode fetch, 2 read, 3 write, 4 port input and 5 port output. Memory addresses 0x0000–0x1FFF select the boot ROM for fetch and read cycles, and a write there selects nothing. When the ROM-overlay flag is set, both reads and writes there select the overlay RAM instead, at overlay address bits 14:0.
- R3: When the RAM-overlay flag is set, 0x2000–0x7FFF selects the overlay RAM. Otherwise 0x6000–0x7FFF selects work RAM, with `workRamAddr` equal to address bits 9:0, and 0x2000–0x5FFF selects nothing. At most one region is selected in any cycle.
- R4: Fetches and reads from 0x8000 up to the cartridge limit select the cartridge, with `cartOffset` equal to address bits 13:0. When address bit 14 is 0, `cartBank` is the last bank (NUM_BANKS-1). When bit 14 is 1, it is the bank register, which is 0 after reset.
- R5: A fetch, read or write at 0xFFC0–0xFFFF loads the bank register with the low address bits. A read in that same cycle already uses the new bank.
- R6: A fetch or read of unmapped memory returns 0xFF. A port input that is not decoded returns 0xFF.
- R7: Port cycles are decoded on address bits 7:5. Group 5 selects the video chip for both directions and returns `vidData` on input. Group 7 on input asserts `padRead`, with `padIdx` equal to address bit 1. Group 7 on output asserts `sndWrite`.
- R8: A port output to group 4 sets keypad mode, and a port output to group 6 sets joystick mode. A controller read returns `padKeyData` in keypad mode and `padDirData` in joystick mode.
- R9: A port output to 0x7F sets the ROM-overlay flag to the inverse of data bit 1. A port output to 0x53 sets the RAM-overlay flag to data bit 0.
- R10: A port output to 0x50 drives BC1 alone. A port output to 0x51 drives BDIR and BC2. A port input from 0x52 drives BC2 and BC1 and returns `psgData`. All three strobes are 0 in every other cycle.
- R11: After reset both overlay flags are clear, joystick mode is selected and the bank register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Bus address |
| busWrData | input | 8 | Data written by the processor |
| cycType | input | 3 | Cycle type (see R2) |
| cycEnd | input | 1 | Final sub-cycle of the current bus cycle |
| romData | input | 8 | Boot ROM read data |
| workRamData | input | 8 | Work RAM read data |
| ovlRamData | input | 8 | Overlay RAM read data |
| cartData | input | 8 | Cartridge read data |
| vidData | input | 8 | Video chip read data |
| padKeyData | input | 8 | Keypad bits of the selected controller |
| padDirData | input | 8 | Direction bits of the selected controller |
| psgData | input | 8 | Sound chip read data |
| romSel | output | 1 | Boot ROM select |
| workRamSel | output | 1 | Work RAM select |
| workRamAddr | output | 10 | Work RAM address |
| ovlRamSel | output | 1 | Overlay RAM select |
| ovlRamAddr | output | 15 | Overlay RAM address |
| cartSel | output | 1 | Cartridge select |
| cartBank | output | 4 | Cartridge bank for the current access |
| cartOffset | output | 14 | Offset inside the 16 KB window |
| busWe | output | 1 | Write or port-output strobe |
| rdData | output | 8 | Read data to the processor |
| vidSel | output | 1 | Video chip select |
| padRead | output | 1 | Controller read |
| padIdx | output | 1 | Controller number |
| keypadMode | output | 1 | 1 when in keypad mode |
| sndWrite | output | 1 | Tone generator write |
| psgBdir | output | 1 | Sound chip BDIR strobe |
| psgBc2 | output | 1 | Sound chip BC2 strobe |
| psgBc1 | output | 1 | Sound chip BC1 strobe |

## Verification
Two functions can act in the same cycle: a cartridge read and a bank switch, when the read lands in the top 64 bytes. The bench reads 0xFFC5 and checks that `cartBank` is already 5 in that cycle. It then reads 0xC000 and checks that the bank is still 5, and reads 0x8000 and checks that the lower window still shows the last bank. A write to 0xFFC9 then shows that a write switches the bank without selecting the cartridge. The overlay flags and the decode meet in the same way: a port output sets a flag, and the access in the next cycle must already see the new mapping.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_FETCH = 3'd1,
    CYC_READ  = 3'd2,
    CYC_WRITE = 3'd3,
    CYC_IN    = 3'd4,
    CYC_OUT   = 3'd5
  } cyc_e;

  typedef struct packed {
    logic romSel;
    logic workSel;
    logic ovlSel;
    logic cartSel;
    logic bankLoad;
    logic rdAccess;
    logic wrAccess;
    logic vidSel;
    logic padRead;
    logic sndWr;
    logic setKeypad;
    logic setJoy;
    logic romFlagWr;
    logic ramFlagWr;
    logic psgAddr;
    logic psgWrite;
    logic psgRead;
  } strobe_t;

endpackage

// File: rtl/cbd_ctrl.sv
module cbd_ctrl
  import cbd_pkg::*;
#(
  parameter logic [15:0] CART_LIMIT  = 16'hFFFF,
  parameter bit          BANK_SWITCH = 1'b1
) (
  input  logic [15:0] addr,
  input  logic [2:0]  cycType,
  input  logic        cycEnd,
  input  logic        romRepl,
  input  logic        ramRepl,
  output strobe_t     stb
);

  localparam logic [15:0] ROM_END   = 16'h2000;
  localparam logic [15:0] LOW_END   = 16'h8000;
  localparam logic [15:0] WORK_BASE = 16'h6000;
  localparam logic [15:0] BANK_HOT  = 16'hFFC0;

  cyc_e cyc;
  logic memCyc;
  logic ioCyc;
  logic isWrite;
  logic isOut;
  logic [2:0] group;
  logic [7:0] port;
  logic bankHit;

  assign cyc     = cyc_e'(cycType);
  assign isWrite = (cyc == CYC_WRITE);
  assign isOut   = (cyc == CYC_OUT);
  assign memCyc  = cycEnd && (cyc == CYC_FETCH || cyc == CYC_READ || isWrite);
  assign ioCyc   = cycEnd && (cyc == CYC_IN || isOut);
  assign group   = addr[7:5];
  assign port    = addr[7:0];

  generate
    if (BANK_SWITCH) begin : gBankOn
      assign bankHit = memCyc && (addr >= BANK_HOT);
    end else begin : gBankOff
      assign bankHit = 1'b0;
    end
  endgenerate

  always_comb begin
    stb = '0;
    stb.bankLoad = bankHit;
    if (memCyc) begin
      stb.rdAccess = !isWrite;
      stb.wrAccess = isWrite;
      if (addr < ROM_END) begin
        if (romRepl)       stb.ovlSel = 1'b1;
        else if (!isWrite) stb.romSel = 1'b1;
      end else if (addr < LOW_END) begin
        if (ramRepl)                stb.ovlSel  = 1'b1;
        else if (addr >= WORK_BASE) stb.workSel = 1'b1;
      end else if (addr <= CART_LIMIT) begin
        stb.cartSel = !isWrite;
      end
    end else if (ioCyc) begin
      stb.rdAccess = !isOut;
      stb.wrAccess = isOut;
      case (group)
        3'd5: stb.vidSel = 1'b1;
        3'd7: begin
          if (isOut) stb.sndWr   = 1'b1;
          else       stb.padRead = 1'b1;
        end
        3'd4: stb.setKeypad = isOut;
        3'd6: stb.setJoy    = isOut;
        default: begin
          if (isOut) begin
            stb.romFlagWr = (port == 8'h7F);
            stb.ramFlagWr = (port == 8'h53);
            stb.psgAddr   = (port == 8'h50);
            stb.psgWrite  = (port == 8'h51);
          end else begin
            stb.psgRead   = (port == 8'h52);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cbd_datapath.sv
module cbd_datapath
  import cbd_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int WORK_AW   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycEnd,
  input  strobe_t           stb,
  input  logic [15:0]       addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        romData,
  input  logic [7:0]        workRamData,
  input  logic [7:0]        ovlRamData,
  input  logic [7:0]        cartData,
  input  logic [7:0]        vidData,
  input  logic [7:0]        padKeyData,
  input  logic [7:0]        padDirData,
  input  logic [7:0]        psgData,
  output logic              romRepl,
  output logic              ramRepl,
  output logic              keypadMode,
  output logic [BANK_W-1:0] cartBank,
  output logic [WORK_AW-1:0] workRamAddr,
  output logic [14:0]       ovlRamAddr,
  output logic [13:0]       cartOffset,
  output logic [7:0]        rdData,
  output logic              psgBdir,
  output logic              psgBc2,
  output logic              psgBc1
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] bankReg;
  logic [BANK_W-1:0] liveBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romRepl    <= 1'b0;
      ramRepl    <= 1'b0;
      keypadMode <= 1'b0;
      bankReg    <= '0;
    end else begin
      if (stb.romFlagWr) romRepl <= ~wrData[1];
      if (stb.ramFlagWr) ramRepl <= wrData[0];
      if (stb.setKeypad) keypadMode <= 1'b1;
      else if (stb.setJoy) keypadMode <= 1'b0;
      if (stb.bankLoad) bankReg <= addr[BANK_W-1:0];
    end
  end

  assign liveBank    = stb.bankLoad ? addr[BANK_W-1:0] : bankReg;
  assign cartBank    = addr[14] ? liveBank : LAST_BANK;
  assign cartOffset  = addr[13:0];
  assign workRamAddr = addr[WORK_AW-1:0];
  assign ovlRamAddr  = addr[14:0];

  always_comb begin
    rdData = 8'hFF;
    if (stb.rdAccess) begin
      if (stb.romSel)       rdData = romData;
      else if (stb.workSel) rdData = workRamData;
      else if (stb.ovlSel)  rdData = ovlRamData;
      else if (stb.cartSel) rdData = cartData;
      else if (stb.vidSel)  rdData = vidData;
      else if (stb.padRead) rdData = keypadMode ? padKeyData : padDirData;
      else if (stb.psgRead) rdData = psgData;
    end
  end

  assign psgBdir = stb.psgWrite;
  assign psgBc2  = stb.psgWrite | stb.psgRead;
  assign psgBc1  = stb.psgAddr  | stb.psgRead;

  // R1: an idle sub-cycle produces no strobes
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cycEnd |-> (stb == '0));

  // R1: state holds across non-terminal sub-cycles
  assert_state_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cycEnd |=> $stable({romRepl, ramRepl, keypadMode, bankReg}));

  // R3: never two memory regions at once
  assert_one_region_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.romSel, stb.workSel, stb.ovlSel, stb.cartSel}));

  // R5: bank register follows the hot-zone address
  assert_bank_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.bankLoad |=> (bankReg == $past(addr[BANK_W-1:0])));

  // R8: group 4 output leaves keypad mode on
  assert_keypad_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setKeypad |=> keypadMode);

  // R9: ROM overlay flag is the inverse of data bit 1
  assert_rom_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.romFlagWr |=> (romRepl == !$past(wrData[1])));

  // R10: sound chip strobes only on its three ports during a final sub-cycle
  assert_psg_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    (psgBdir || psgBc2 || psgBc1) |-> (cycEnd && addr[7:2] == 6'b010100));

endmodule

// File: rtl/console_bus_decoder.sv
module console_bus_decoder
  import cbd_pkg::*;
#(
  parameter logic [15:0] CART_LIMIT  = 16'hFFFF,
  parameter bit          BANK_SWITCH = 1'b1,
  parameter int          NUM_BANKS   = 16,
  parameter int          WORK_AW     = 10,
  localparam int         BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       busAddr,
  input  logic [7:0]        busWrData,
  input  logic [2:0]        cycType,
  input  logic              cycEnd,
  input  logic [7:0]        romData,
  input  logic [7:0]        workRamData,
  input  logic [7:0]        ovlRamData,
  input  logic [7:0]        cartData,
  input  logic [7:0]        vidData,
  input  logic [7:0]        padKeyData,
  input  logic [7:0]        padDirData,
  input  logic [7:0]        psgData,
  output logic              romSel,
  output logic              workRamSel,
  output logic [WORK_AW-1:0] workRamAddr,
  output logic              ovlRamSel,
  output logic [14:0]       ovlRamAddr,
  output logic              cartSel,
  output logic [BANK_W-1:0] cartBank,
  output logic [13:0]       cartOffset,
  output logic              busWe,
  output logic [7:0]        rdData,
  output logic              vidSel,
  output logic              padRead,
  output logic              padIdx,
  output logic              keypadMode,
  output logic              sndWrite,
  output logic              psgBdir,
  output logic              psgBc2,
  output logic              psgBc1
);

  strobe_t stb;
  logic romRepl;
  logic ramRepl;

  cbd_ctrl #(
    .CART_LIMIT (CART_LIMIT),
    .BANK_SWITCH(BANK_SWITCH)
  ) uCtrl (
    .addr   (busAddr),
    .cycType(cycType),
    .cycEnd (cycEnd),
    .romRepl(romRepl),
    .ramRepl(ramRepl),
    .stb    (stb)
  );

  cbd_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .WORK_AW  (WORK_AW)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .cycEnd     (cycEnd),
    .stb        (stb),
    .addr       (busAddr),
    .wrData     (busWrData),
    .romData    (romData),
    .workRamData(workRamData),
    .ovlRamData (ovlRamData),
    .cartData   (cartData),
    .vidData    (vidData),
    .padKeyData (padKeyData),
    .padDirData (padDirData),
    .psgData    (psgData),
    .romRepl    (romRepl),
    .ramRepl    (ramRepl),
    .keypadMode (keypadMode),
    .cartBank   (cartBank),
    .workRamAddr(workRamAddr),
    .ovlRamAddr (ovlRamAddr),
    .cartOffset (cartOffset),
    .rdData     (rdData),
    .psgBdir    (psgBdir),
    .psgBc2     (psgBc2),
    .psgBc1     (psgBc1)
  );

  assign romSel     = stb.romSel;
  assign workRamSel = stb.workSel;
  assign ovlRamSel  = stb.ovlSel;
  assign cartSel    = stb.cartSel;
  assign busWe      = stb.wrAccess;
  assign vidSel     = stb.vidSel;
  assign padRead    = stb.padRead;
  assign padIdx     = busAddr[1];
  assign sndWrite   = stb.sndWr;

endmodule

// File: tb/console_bus_decoder_test.sv
module console_bus_decoder_test;

  localparam logic [7:0] ROMD = 8'hA1, WRKD = 8'hB2, OVLD = 8'hC3, CARTD = 8'hD4;
  localparam logic [7:0] VIDD = 8'hE5, KEYD = 8'h5A, DIRD = 8'h3C, PSGD = 8'h96;

  // {cycType, addr, {rom,work,ovl,cart}, rdData}
  localparam int NVEC = 10;
  localparam logic [30:0] VEC [NVEC] = '{
    {3'd2, 16'h0005, 4'b1000, ROMD},
    {3'd1, 16'h1FFF, 4'b1000, ROMD},
    {3'd2, 16'h6001, 4'b0100, WRKD},
    {3'd2, 16'h7C01, 4'b0100, WRKD},
    {3'd2, 16'h3000, 4'b0000, 8'hFF},
    {3'd2, 16'h8000, 4'b0001, CARTD},
    {3'd1, 16'hC123, 4'b0001, CARTD},
    {3'd3, 16'h0100, 4'b0000, 8'hFF},
    {3'd4, 16'h00FF, 4'b0000, DIRD},
    {3'd4, 16'h0000, 4'b0000, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [2:0] cycType = '0;
  logic cycEnd = 1'b0;
  logic romSel, workRamSel, ovlRamSel, cartSel, busWe, vidSel, padRead, padIdx;
  logic keypadMode, sndWrite, psgBdir, psgBc2, psgBc1;
  logic [9:0] workRamAddr;
  logic [14:0] ovlRamAddr;
  logic [3:0] cartBank;
  logic [13:0] cartOffset;
  logic [7:0] rdData;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  console_bus_decoder uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .cycType(cycType), .cycEnd(cycEnd), .romData(ROMD), .workRamData(WRKD),
    .ovlRamData(OVLD), .cartData(CARTD), .vidData(VIDD), .padKeyData(KEYD),
    .padDirData(DIRD), .psgData(PSGD), .romSel(romSel), .workRamSel(workRamSel),
    .workRamAddr(workRamAddr), .ovlRamSel(ovlRamSel), .ovlRamAddr(ovlRamAddr),
    .cartSel(cartSel), .cartBank(cartBank), .cartOffset(cartOffset), .busWe(busWe),
    .rdData(rdData), .vidSel(vidSel), .padRead(padRead), .padIdx(padIdx),
    .keypadMode(keypadMode), .sndWrite(sndWrite), .psgBdir(psgBdir),
    .psgBc2(psgBc2), .psgBc1(psgBc1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one final sub-cycle; outputs are checked 2 ns after the falling edge
  task automatic drive(input logic [2:0] t, input logic [15:0] a, input logic [7:0] d, input logic e);
    @(negedge clk);
    cycType = t; busAddr = a; busWrData = d; cycEnd = e;
    #2;
  endtask

  task automatic idle();
    drive(3'd0, 16'h0000, 8'h00, 1'b0);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R11: reset state
    idle();
    check("R11 keypad mode after reset", {31'd0, keypadMode}, 32'd0);
    drive(3'd2, 16'hC000, 8'h00, 1'b1);
    check("R11 bank after reset", {28'd0, cartBank}, 32'd0);
    drive(3'd2, 16'h0000, 8'h00, 1'b1);
    check("R11 ROM visible after reset", {31'd0, romSel}, 32'd1);

    // R2 R3 R4 R6 R8: vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][30:28], VEC[i][27:12], 8'h00, 1'b1);
      check("R2/R3/R4 region vec", {28'd0, romSel, workRamSel, ovlRamSel, cartSel}, {28'd0, VEC[i][11:8]});
      check("R6 read data vec", {24'd0, rdData}, {24'd0, VEC[i][7:0]});
    end

    // R3 work RAM mirror, R4 window banks and offset
    drive(3'd2, 16'h7E05, 8'h00, 1'b1);
    check("R3 work mirror", {22'd0, workRamAddr}, 32'h205);
    drive(3'd2, 16'hBFFE, 8'h00, 1'b1);
    check("R4 lower window last bank", {28'd0, cartBank}, 32'd15);
    check("R4 offset", {18'd0, cartOffset}, 32'h3FFE);

    // R1: non-final sub-cycle
    drive(3'd2, 16'h0000, 8'h00, 1'b0);
    check("R1 no select", {28'd0, romSel, workRamSel, ovlRamSel, cartSel}, 32'd0);
    check("R1 rdData", {24'd0, rdData}, 32'hFF);
    drive(3'd5, 16'h007F, 8'h00, 1'b0);
    check("R1 no write strobe", {31'd0, busWe}, 32'd0);
    drive(3'd5, 16'h0051, 8'h00, 1'b0);
    check("R1 psg quiet", {29'd0, psgBdir, psgBc2, psgBc1}, 32'd0);
    drive(3'd2, 16'h0000, 8'h00, 1'b1);
    check("R1 flag unchanged", {31'd0, romSel}, 32'd1);

    // R9 ROM overlay
    drive(3'd5, 16'h007F, 8'h00, 1'b1);
    check("R9 output strobe", {31'd0, busWe}, 32'd1);
    drive(3'd2, 16'h0123, 8'h00, 1'b1);
    check("R9 ROM overlay select", {28'd0, romSel, workRamSel, ovlRamSel, cartSel}, 32'b0010);
    check("R2 overlay data", {24'd0, rdData}, {24'd0, OVLD});
    check("R2 overlay addr", {17'd0, ovlRamAddr}, 32'h0123);
    drive(3'd3, 16'h0040, 8'h11, 1'b1);
    check("R2 overlay write", {30'd0, ovlRamSel, busWe}, 32'b11);
    drive(3'd5, 16'h007F, 8'h02, 1'b1);
    drive(3'd2, 16'h0000, 8'h00, 1'b1);
    check("R9 ROM overlay off", {31'd0, romSel}, 32'd1);

    // R9 RAM overlay
    drive(3'd5, 16'h0053, 8'h01, 1'b1);
    drive(3'd2, 16'h3000, 8'h00, 1'b1);
    check("R3 RAM overlay low", {28'd0, romSel, workRamSel, ovlRamSel, cartSel}, 32'b0010);
    drive(3'd2, 16'h6000, 8'h00, 1'b1);
    check("R3 RAM overlay over work", {28'd0, romSel, workRamSel, ovlRamSel, cartSel}, 32'b0010);
    drive(3'd5, 16'h0053, 8'h00, 1'b1);
    drive(3'd2, 16'h6000, 8'h00, 1'b1);
    check("R9 RAM overlay off", {31'd0, workRamSel}, 32'd1);

    // R5 bank switch, same-cycle read
    drive(3'd2, 16'hFFC5, 8'h00, 1'b1);
    check("R5 same-cycle bank", {28'd0, cartBank}, 32'd5);
    check("R5 cart data", {24'd0, rdData}, {24'd0, CARTD});
    drive(3'd2, 16'hC000, 8'h00, 1'b1);
    check("R5 bank kept", {28'd0, cartBank}, 32'd5);
    drive(3'd2, 16'h8000, 8'h00, 1'b1);
    check("R4 lower window fixed", {28'd0, cartBank}, 32'd15);
    drive(3'd3, 16'hFFC9, 8'h00, 1'b1);
    check("R5 write no cart select", {31'd0, cartSel}, 32'd0);
    drive(3'd2, 16'hC000, 8'h00, 1'b1);
    check("R5 write switched bank", {28'd0, cartBank}, 32'd9);

    // R7 / R8 ports
    drive(3'd4, 16'h00A0, 8'h00, 1'b1);
    check("R7 video select", {31'd0, vidSel}, 32'd1);
    check("R7 video data", {24'd0, rdData}, {24'd0, VIDD});
    drive(3'd5, 16'h00E0, 8'h00, 1'b1);
    check("R7 tone write", {31'd0, sndWrite}, 32'd1);
    drive(3'd5, 16'h0080, 8'h00, 1'b1);
    drive(3'd4, 16'h00E2, 8'h00, 1'b1);
    check("R8 keypad mode", {31'd0, keypadMode}, 32'd1);
    check("R7 pad read/idx", {30'd0, padRead, padIdx}, 32'b11);
    check("R8 keypad data", {24'd0, rdData}, {24'd0, KEYD});
    drive(3'd5, 16'h00C0, 8'h00, 1'b1);
    drive(3'd4, 16'h00FC, 8'h00, 1'b1);
    check("R8 joystick data", {24'd0, rdData}, {24'd0, DIRD});
    check("R7 pad idx 0", {31'd0, padIdx}, 32'd0);

    // R10 sound chip strobes {bdir,bc2,bc1}
    drive(3'd5, 16'h0050, 8'h07, 1'b1);
    check("R10 address latch", {29'd0, psgBdir, psgBc2, psgBc1}, 32'b001);
    drive(3'd5, 16'h0051, 8'h3F, 1'b1);
    check("R10 data write", {29'd0, psgBdir, psgBc2, psgBc1}, 32'b110);
    drive(3'd4, 16'h0052, 8'h00, 1'b1);
    check("R10 data read", {29'd0, psgBdir, psgBc2, psgBc1}, 32'b011);
    check("R10 read data", {24'd0, rdData}, {24'd0, PSGD});
    idle();
    check("R10 strobes off", {29'd0, psgBdir, psgBc2, psgBc1}, 32'd0);
    drive(3'd4, 16'h0040, 8'h00, 1'b1);
    check("R6 unknown port", {24'd0, rdData}, 32'hFF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule